// File: doc/BRIEF.md
# Compare/Capture Timer

A 32-bit general-purpose timer with a small word-addressed register port. A programmable prescaler produces a count tick, and a 32-bit up-counter advances on each tick while the timer runs. In free-running mode the counter wraps at its maximum and flags a rollover. In restart mode the counter returns to zero on the tick that finds it equal to compare value 1. Three compare channels watch the counter. Each raises its own flag on a match and drives an output pin according to its action mode. Software can also force a channel's action without a match. Two capture channels synchronise an input pin and detect its edges. On a selected edge a channel latches the counter value and raises a flag.

All flags live in one status register and are cleared by writing 1 to them. An enable register selects which flags drive the single interrupt line. A self-clearing software-reset bit returns the counting state, the flags and the pins to their reset values. Configuration is left as written.

Each compare pin is driven by a two-state machine. The states are STEADY and PULSE. In STEADY the pin shows a level register, or idles high when the channel is in pulse mode. Three transitions are named:
- arm: STEADY moves to PULSE when an action occurs in pulse mode.
- expire: PULSE moves to STEADY on the next count tick that has no new action.
- abandon: PULSE moves to STEADY when the mode stops being pulse.

A software reset forces the state to STEADY.

Top module: `gp_timer`

## Requirements
- R1: After reset, every register reads 0, all compare pins are low and the interrupt line is low.
- R2: The registers sit at these byte addresses: control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 1/2/3 at 0x10/0x14/0x18, capture 1/2 at 0x1C/0x20 and counter 0x24. Only prescaler bits 11:0 and status and enable bits 5:0 are stored; all other bits read 0. The control force bits 31:29 always read 0.
- R3: Control bit 0 is the run bit. While it is set, the counter advances once every (prescaler + 1) cycles. The first advance comes prescaler + 1 cycles after the write that sets the bit. While the bit is clear, the counter holds its value.
- R4: With control bit 9 clear (restart mode), a tick that finds the counter equal to compare 1 loads 0 instead of incrementing.
- R5: With control bit 9 set (free-run mode), a tick at 0xFFFFFFFF wraps the counter to 0 and sets status bit 5. A write to 0x24 loads the counter.
- R6: A tick that finds the counter equal to compare n sets status bit n-1 (bits 0, 1, 2).
- R7: Each compare channel has a 3-bit mode field: channel 1 at control bits 22:20, channel 2 at 25:23 and channel 3 at 28:26. On an action, code 1 toggles the pin, code 2 drives it low and code 3 drives it high. Code 0 leaves the pin unchanged. Codes 5 to 7 act like code 0.
- R8: Mode code 4 makes the pin idle high. A match drives the pin low from that edge until the next count tick.
- R9: Writing 1 to control bit 29, 30 or 31 performs the action of channel 1, 2 or 3 on the edge after the write. No counter match is needed, and no status flag is set.
- R10: Each capture channel has a 2-bit mode field: channel 1 at control bits 17:16 and channel 2 at 19:18. The codes are 0 off, 1 rising, 2 falling and 3 both edges. The input passes two synchroniser flops. On the third rising clock edge after an input change, a qualifying edge loads the counter into the capture register and sets status bit 3 or 4.
- R11: Writing 1 to a status bit clears it. An event that sets the same bit on the same edge wins, and the bit stays 1.
- R12: The interrupt line is high exactly when some status bit and its enable bit are both 1.
- R13: Writing 1 to control bit 15 makes that bit read 1 for one cycle. On the following edge, the counter, prescaler state, status and pin states clear, and the bit reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| cap_in | input | 2 | Capture input pins |
| cmp_out | output | 3 | Compare output pins |
| irq | output | 1 | Interrupt request |

## Verification
The set and clear of one status flag can meet on the same edge. A compare-1 match and a software write-one-to-clear of the same flag can both arrive there. The bench runs the counter in restart mode with a prescaler of zero and compare 1 at 3, so the match edge falls four edges after the enable write. It then times a status write to land on exactly that edge. The flag must still read 1 with the interrupt high. The same write issued one edge later must clear it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_PRE  = 6'h04;
    localparam logic [ADDR_W-1:0] ADR_STAT = 6'h08;
    localparam logic [ADDR_W-1:0] ADR_IEN  = 6'h0C;
    localparam int CMP_BASE = 16;

    localparam int BIT_RUN  = 0;
    localparam int BIT_FREE = 9;
    localparam int BIT_SRST = 15;
    localparam int CAPM_LO  = 16;

    typedef enum logic [2:0] {
        OM_OFF    = 3'd0,
        OM_TOGGLE = 3'd1,
        OM_CLEAR  = 3'd2,
        OM_SET    = 3'd3,
        OM_PULSE  = 3'd4
    } om_e;

    typedef enum logic [1:0] {
        IM_OFF  = 2'd0,
        IM_RISE = 2'd1,
        IM_FALL = 2'd2,
        IM_BOTH = 2'd3
    } im_e;

    typedef enum logic {
        PIN_STEADY = 1'b0,
        PIN_PULSE  = 1'b1
    } pin_st_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] pc_q;

    assign tick = run && !clr && (pc_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    pc_q <= '0;
        else if (clr || !run || tick)  pc_q <= '0;
        else                           pc_q <= pc_q + 1'b1;
    end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ocr,
    input  logic [2:0]       mode,
    input  logic             force_act,
    output logic             match,
    output logic             pin
);
    pin_st_e state_q, state_nxt;
    logic    lvl_q;
    logic    act;
    logic    is_pulse;

    assign is_pulse = (om_e'(mode) == OM_PULSE);
    assign match    = tick && (cnt == ocr);
    assign act      = match || force_act;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= PIN_STEADY;
        else if (clr) state_q <= PIN_STEADY;
        else          state_q <= state_nxt;
    end

    // transitions: arm, expire, abandon
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            PIN_STEADY: if (act && is_pulse) state_nxt = PIN_PULSE;
            PIN_PULSE: begin
                if (!is_pulse)  state_nxt = PIN_STEADY;
                else if (act)   state_nxt = PIN_PULSE;
                else if (tick)  state_nxt = PIN_STEADY;
            end
            default: state_nxt = PIN_STEADY;
        endcase
    end

    // level register for toggle/clear/set actions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   lvl_q <= 1'b0;
        else if (clr) lvl_q <= 1'b0;
        else if (act) begin
            case (om_e'(mode))
                OM_TOGGLE: lvl_q <= ~lvl_q;
                OM_CLEAR:  lvl_q <= 1'b0;
                OM_SET:    lvl_q <= 1'b1;
                default:   lvl_q <= lvl_q;
            endcase
        end
    end

    // output process
    always_comb begin
        if (is_pulse) pin = (state_q != PIN_PULSE);
        else          pin = lvl_q;
    end

    AST_PULSE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pulse && state_q == PIN_PULSE && tick && !act && !clr) |=> (pin || !is_pulse)); // R8
endmodule

// File: rtl/tmr_cap_chan.sv
module tmr_cap_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] cnt,
    output logic             evt,
    output logic [CNT_W-1:0] value
);
    logic s1_q, s2_q, prev_q;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign rise = s2_q && !prev_q;
    assign fall = !s2_q && prev_q;

    always_comb begin
        evt = 1'b0;
        unique case (im_e'(mode))
            IM_OFF:  evt = 1'b0;
            IM_RISE: evt = rise;
            IM_FALL: evt = fall;
            IM_BOTH: evt = rise || fall;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (evt) value <= cnt;
    end

    AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (value == $past(cnt))); // R10
endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12,
    parameter int N_CMP = 3,
    parameter int N_CAP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CAP-1:0]  cap_in,
    output logic [N_CMP-1:0]  cmp_out,
    output logic              irq
);
    localparam int CAP_BASE = CMP_BASE + 4 * N_CMP;
    localparam int CNT_ADDR = CAP_BASE + 4 * N_CAP;
    localparam int CMPM_LO  = CAPM_LO + 2 * N_CAP;
    localparam int FRC_LO   = CMPM_LO + 3 * N_CMP;
    localparam int NEV      = N_CMP + N_CAP + 1;
    localparam int ROV_BIT  = NEV - 1;
    localparam logic [ADDR_W-1:0] ADR_CNT = ADDR_W'(CNT_ADDR);

    logic                 en_q, frr_q, swr_q;
    logic [2*N_CAP-1:0]   im_q;
    logic [3*N_CMP-1:0]   om_q;
    logic [N_CMP-1:0]     force_q;
    logic [PRE_W-1:0]     pre_q;
    logic [NEV-1:0]       ie_q, st_q, events;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     ocr_q   [N_CMP];
    logic [CNT_W-1:0]     cap_val [N_CAP];
    logic [N_CMP-1:0]     cmp_match;
    logic [N_CAP-1:0]     cap_evt;
    logic                 tick, rov_evt;
    logic                 wr_ctrl, wr_pre, wr_st, wr_ie, wr_cnt;

    assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_pre  = bus_wr && (bus_addr == ADR_PRE);
    assign wr_st   = bus_wr && (bus_addr == ADR_STAT);
    assign wr_ie   = bus_wr && (bus_addr == ADR_IEN);
    assign wr_cnt  = bus_wr && (bus_addr == ADR_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; frr_q <= 1'b0; swr_q <= 1'b0;
            im_q <= '0; om_q <= '0; force_q <= '0;
        end else begin
            swr_q   <= wr_ctrl && bus_wdata[BIT_SRST];
            force_q <= wr_ctrl ? bus_wdata[FRC_LO +: N_CMP] : '0;
            if (wr_ctrl) begin
                en_q  <= bus_wdata[BIT_RUN];
                frr_q <= bus_wdata[BIT_FREE];
                im_q  <= bus_wdata[CAPM_LO +: 2*N_CAP];
                om_q  <= bus_wdata[CMPM_LO +: 3*N_CMP];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ie_q  <= '0;
        end else begin
            if (wr_pre) pre_q <= bus_wdata[PRE_W-1:0];
            if (wr_ie)  ie_q  <= bus_wdata[NEV-1:0];
        end
    end

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(swr_q), .run(en_q), .div(pre_q), .tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (swr_q)  cnt_q <= '0;
        else if (wr_cnt) cnt_q <= bus_wdata[CNT_W-1:0];
        else if (tick)   cnt_q <= (cmp_match[0] && !frr_q) ? '0 : cnt_q + 1'b1;
    end

    assign rov_evt = tick && (&cnt_q);

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] ADR_OCR = ADDR_W'(CMP_BASE + 4 * i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                ocr_q[i] <= '0;
            else if (bus_wr && bus_addr == ADR_OCR)    ocr_q[i] <= bus_wdata[CNT_W-1:0];
        end
        tmr_cmp_chan #(.CNT_W(CNT_W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .clr(swr_q), .tick(tick), .cnt(cnt_q),
            .ocr(ocr_q[i]), .mode(om_q[3*i +: 3]), .force_act(force_q[i]),
            .match(cmp_match[i]), .pin(cmp_out[i])
        );
    end

    for (genvar j = 0; j < N_CAP; j++) begin : g_cap
        tmr_cap_chan #(.CNT_W(CNT_W)) u_cap (
            .clk(clk), .rst_n(rst_n), .pin_in(cap_in[j]), .mode(im_q[2*j +: 2]),
            .cnt(cnt_q), .evt(cap_evt[j]), .value(cap_val[j])
        );
    end

    assign events = {rov_evt, cap_evt, cmp_match};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st_q <= '0;
        else if (swr_q) st_q <= '0;
        else            st_q <= (st_q & ~(wr_st ? bus_wdata[NEV-1:0] : '0)) | events;
    end

    assign irq = |(st_q & ie_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_CTRL) begin
            bus_rdata[BIT_RUN]               = en_q;
            bus_rdata[BIT_FREE]              = frr_q;
            bus_rdata[BIT_SRST]              = swr_q;
            bus_rdata[CAPM_LO +: 2*N_CAP]    = im_q;
            bus_rdata[CMPM_LO +: 3*N_CMP]    = om_q;
        end
        if (bus_addr == ADR_PRE)  bus_rdata[PRE_W-1:0] = pre_q;
        if (bus_addr == ADR_STAT) bus_rdata[NEV-1:0]   = st_q;
        if (bus_addr == ADR_IEN)  bus_rdata[NEV-1:0]   = ie_q;
        if (bus_addr == ADR_CNT)  bus_rdata[CNT_W-1:0] = cnt_q;
        for (int i = 0; i < N_CMP; i++)
            if (bus_addr == ADDR_W'(CMP_BASE + 4 * i)) bus_rdata[CNT_W-1:0] = ocr_q[i];
        for (int j = 0; j < N_CAP; j++)
            if (bus_addr == ADDR_W'(CAP_BASE + 4 * j)) bus_rdata[CNT_W-1:0] = cap_val[j];
    end

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !wr_cnt && !swr_q) |=> $stable(cnt_q)); // R3
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_match[0] && !frr_q && !wr_cnt && !swr_q) |=> (cnt_q == '0)); // R4
    AST_ROV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rov_evt && !swr_q) |=> st_q[ROV_BIT]); // R5
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_match[0] && wr_st && bus_wdata[0] && !swr_q) |=> st_q[0]); // R11
    AST_SRST_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        swr_q |=> (st_q == '0 && cnt_q == '0)); // R13
endmodule

// File: tb/tb_gp_timer.sv
module tb_gp_timer;
    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] A_CTRL = 6'h00, A_PRE = 6'h04, A_ST = 6'h08, A_IE = 6'h0C;
    localparam logic [5:0] A_C1 = 6'h10, A_C2 = 6'h14, A_C3 = 6'h18;
    localparam logic [5:0] A_K1 = 6'h1C, A_K2 = 6'h20, A_CNT = 6'h24;
    localparam logic [31:0] RUN = 32'h1, FREE = 32'h200, SRST = 32'h8000;

    typedef struct packed {
        logic [11:0] pre;
        logic [31:0] cmp1;
        logic [15:0] waitc;
        logic        free;
        logic [31:0] expct;
    } vec_t;

    // R3/R4/R5 counting vectors: count = floor(wait/(pre+1)), restart wraps mod (cmp1+1)
    localparam vec_t VECS [4] = '{
        '{12'd0, 32'd9,    16'd25, 1'b0, 32'd5},
        '{12'd2, 32'd4,    16'd20, 1'b0, 32'd1},
        '{12'd3, 32'd1000, 16'd40, 1'b1, 32'd10},
        '{12'd1, 32'd2,    16'd13, 1'b0, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  cap_in;
    logic [2:0]  cmp_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    gp_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .cmp_out(cmp_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic soft_reset();
        bus_write(A_CTRL, SRST);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd, c1;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; cap_in = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 10; i++) begin
            bus_read(6'(4 * i), rd);
            chk("R1 register reset", rd, 32'h0);
        end
        chk("R1 pins reset", {29'b0, cmp_out}, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);

        // R2 storage masks
        bus_write(A_PRE, 32'hFFFF_FFFF);
        bus_read(A_PRE, rd); chk("R2 prescaler mask", rd, 32'h0000_0FFF);
        bus_write(A_IE, 32'hFFFF_FFFF);
        bus_read(A_IE, rd); chk("R2 enable mask", rd, 32'h0000_003F);
        bus_write(A_IE, 32'h0);
        bus_write(A_C3, 32'hDEAD_BEEF);
        bus_read(A_C3, rd); chk("R2 compare3 readback", rd, 32'hDEAD_BEEF);
        bus_write(A_CTRL, 32'hE000_0000);
        bus_read(A_CTRL, rd); chk("R2 force bits read zero", rd, 32'h0);

        // vector table: R3 prescaling, R4 restart, free counting
        foreach (VECS[k]) begin
            soft_reset();
            bus_write(A_PRE, {20'b0, VECS[k].pre});
            bus_write(A_C1, VECS[k].cmp1);
            bus_write(A_CTRL, RUN | (VECS[k].free ? FREE : 32'h0));
            repeat (int'(VECS[k].waitc)) @(negedge clk);
            bus_read(A_CNT, rd);
            chk(VECS[k].free ? "R3 free count" : "R4 restart count", rd, VECS[k].expct);
            bus_write(A_CTRL, 32'h0);
            bus_read(A_CNT, c1);
            repeat (5) @(negedge clk);
            bus_read(A_CNT, rd);
            chk("R3 hold while stopped", rd, c1);
        end

        // R6 / R11 / R12: compare flag, set-beats-clear, irq
        soft_reset();
        bus_write(A_PRE, 32'd0);
        bus_write(A_C1, 32'd3);
        bus_write(A_C2, 32'd0);
        bus_write(A_IE, 32'h1);
        bus_write(A_CTRL, RUN);
        repeat (3) @(negedge clk);
        bus_read(A_ST, rd); chk("R6 flag not before match", rd & 32'h1, 32'h0);
        chk("R12 irq low before match", {31'b0, irq}, 32'h0);
        bus_write(A_ST, 32'h1);
        bus_read(A_ST, rd); chk("R11 set wins over clear", rd & 32'h1, 32'h1);
        chk("R12 irq on enabled flag", {31'b0, irq}, 32'h1);
        bus_write(A_ST, 32'h1);
        bus_read(A_ST, rd); chk("R11 write one clears", rd & 32'h1, 32'h0);
        chk("R12 irq after clear", {31'b0, irq}, 32'h0);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_ST, rd); chk("R6 compare2 flag", (rd >> 1) & 32'h1, 32'h1);
        bus_write(A_IE, 32'h0);
        chk("R12 masked flag", {31'b0, irq}, 32'h0);
        bus_write(A_IE, 32'h2);
        chk("R12 unmasked flag", {31'b0, irq}, 32'h1);
        bus_write(A_IE, 32'h0);

        // R5 rollover in free-run mode
        soft_reset();
        bus_write(A_CNT, 32'hFFFF_FFFE);
        bus_write(A_CTRL, RUN | FREE);
        @(negedge clk);
        bus_read(A_CNT, rd); chk("R5 counter at max", rd, 32'hFFFF_FFFF);
        bus_read(A_ST, rd); chk("R5 no rollover yet", (rd >> 5) & 32'h1, 32'h0);
        @(negedge clk);
        bus_read(A_CNT, rd); chk("R5 wrap to zero", rd, 32'h0);
        bus_read(A_ST, rd); chk("R5 rollover flag", (rd >> 5) & 32'h1, 32'h1);

        // R7 / R8 compare actions: ch1 set @5 (restart), ch2 toggle @2, ch3 pulse @4
        soft_reset();
        bus_write(A_C1, 32'd5);
        bus_write(A_C2, 32'd2);
        bus_write(A_C3, 32'd4);
        bus_write(A_CTRL, (32'd3 << 20) | (32'd1 << 23) | (32'd4 << 26));
        chk("R8 pulse pin idles high", {29'b0, cmp_out}, 32'h4);
        bus_write(A_CTRL, (32'd3 << 20) | (32'd1 << 23) | (32'd4 << 26) | RUN);
        for (int i = 1; i <= 9; i++) begin
            logic [2:0] e;
            @(negedge clk);
            e[0] = (i >= 6);
            e[1] = (i >= 3) ^ (i >= 9);
            e[2] = (i != 5);
            chk("R7 R8 pin actions", {29'b0, cmp_out}, {29'b0, e});
        end
        bus_write(A_CTRL, (32'd3 << 20) | (32'd1 << 23) | (32'd4 << 26));
        bus_write(A_ST, 32'h3F);

        // R9 force: ch1 toggle, ch2 set, ch3 toggle
        bus_write(A_CTRL, (32'd1 << 20) | (32'd3 << 23) | (32'd1 << 26) | 32'hE000_0000);
        chk("R9 before forced action", {29'b0, cmp_out}, 32'h1);
        @(negedge clk);
        chk("R9 forced action", {29'b0, cmp_out}, 32'h6);
        bus_read(A_ST, rd); chk("R9 force sets no flag", rd & 32'h7, 32'h0);
        bus_write(A_CTRL, 32'hE000_0000);
        @(negedge clk);
        chk("R7 mode zero ignores force", {29'b0, cmp_out}, 32'h6);
        bus_write(A_CTRL, (32'd2 << 23) | 32'h4000_0000);
        @(negedge clk);
        chk("R7 clear action", {29'b0, cmp_out}, 32'h4);

        // R10 capture: ch1 rising, ch2 falling
        soft_reset();
        bus_write(A_CNT, 32'd1234);
        bus_write(A_CTRL, (32'd1 << 16) | (32'd2 << 18));
        cap_in = 2'b11;
        repeat (2) @(negedge clk);
        bus_read(A_K1, rd); chk("R10 capture not before sync", rd, 32'h0);
        @(negedge clk);
        bus_read(A_K1, rd); chk("R10 rising capture", rd, 32'd1234);
        bus_read(A_ST, rd); chk("R10 capture flags after rise", rd & 32'h18, 32'h08);
        bus_write(A_CNT, 32'd777);
        cap_in = 2'b00;
        repeat (3) @(negedge clk);
        bus_read(A_K2, rd); chk("R10 falling capture", rd, 32'd777);
        bus_read(A_K1, rd); chk("R10 rising mode ignores fall", rd, 32'd1234);
        bus_read(A_ST, rd); chk("R10 capture2 flag", rd & 32'h10, 32'h10);
        bus_write(A_CTRL, 32'd3 << 16);
        bus_write(A_CNT, 32'd55);
        cap_in = 2'b01;
        repeat (3) @(negedge clk);
        bus_read(A_K1, rd); chk("R10 both-edge capture", rd, 32'd55);
        bus_write(A_CTRL, 32'h0);
        bus_write(A_CNT, 32'd66);
        cap_in = 2'b00;
        repeat (3) @(negedge clk);
        bus_read(A_K1, rd); chk("R10 capture off", rd, 32'd55);

        // R13 software reset
        bus_write(A_CTRL, RUN | SRST);
        bus_read(A_CTRL, rd); chk("R13 reset bit visible", rd, 32'h0000_8001);
        @(negedge clk);
        bus_read(A_CTRL, rd); chk("R13 reset bit self-clears", rd, 32'h0000_0001);
        bus_read(A_ST, rd); chk("R13 status cleared", rd, 32'h0);
        bus_read(A_CNT, rd); chk("R13 counter cleared", rd, 32'h0);
        chk("R13 pins cleared", {29'b0, cmp_out}, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule